// File: doc/BRIEF.md
# Over-discharge Power-Fail Sequencer

This block decides what a battery pack does when one of its cells sags to the over-discharge level. The analog side supplies a single flag that is high while any cell sits at or below the over-discharge threshold. The block first gives the host an early warning on an active-low power-fail output. If the cell is still low when a longer shutdown window runs out, the block turns off the discharge path, drops the auxiliary supply to the host, pulls the current-sense line low and removes internal bias. The pack then sits in a latched zero-current state.

A high level on the power-down request input forces the same latched state at any time, whatever the cell voltages are. This is used to store a pack for shipping. The only way out of the latched state is an external high level on the sense line, reported through the recovery flag. If the cell is still low at that point, the warning sequence starts again. All delays are counted in periods of an external tick, and each delay length is a parameter.

The control is one explicit state machine with four states. ST_NORMAL has all outputs in the run condition. ST_WARN_WAIT counts the warning delay. ST_WARNED holds the power-fail output low and counts the shutdown delay. ST_POWER_DOWN is the latched off state. The transitions are:
- normal to warn-wait when a cell goes low;
- warn-wait back to normal when the cell recovers;
- warn-wait to warned when the warning delay expires;
- warned back to normal (abort) when the cell recovers and the minimum pulse has elapsed;
- warned to power-down when the shutdown delay expires;
- any active state to power-down on a request;
- power-down to normal or to warn-wait on recovery.

Top module: `odp_pwrfail_seq`

## Requirements
- R1: After reset the outputs are pwr_fail_n=1, dis_off=0, aux_on=1, sense_pull_low=0 and bias_en=1.
- R2: While cell_low stays high, pwr_fail_n goes low on the clock edge that carries the WARN_TICKS-th tick counted after the block has entered the warn-wait state. Entering that state takes one edge after cell_low rises.
- R3: If cell_low falls during warn-wait, the block returns to normal on the next edge and no power-fail pulse is issued.
- R4: Once low, pwr_fail_n stays low until at least MIN_PULSE_TICKS ticks have passed. After that, a low cell_low at an edge returns it high, and the block is back in normal with discharge still on.
- R5: In the warned state, on the edge that carries the SHUT_TICKS-th tick, the block enters power-down: dis_off=1, aux_on=0, sense_pull_low=1, bias_en=0, with pwr_fail_n released to 1.
- R6: In power-down, cell_low, pdwn_req and tick have no effect; the outputs hold until the recovery flag is high.
- R7: sense_high at an edge in power-down leaves the latched state: dis_off returns to 0, and aux_on, bias_en and sense_pull_low return to their run values.
- R8: If cell_low is high when recovery happens, the block enters warn-wait directly. pwr_fail_n goes low again WARN_TICKS ticks later.
- R9: pdwn_req high at an edge in warn-wait or warned forces power-down on that edge, cutting any warning short.
- R10: Recovery with cell_low low returns to normal, and no warning follows.
- R11: pdwn_req high in normal forces power-down even when all cells are above the threshold, and the state stays latched after the request is withdrawn.
- R12: The delay timers advance only on edges where tick is high. Without ticks, neither the warning delay, the shutdown delay nor the minimum pulse makes progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse that advances the delay timers |
| cell_low | input | 1 | High while any cell is at or below the over-discharge threshold |
| pdwn_req | input | 1 | Forced power-down request, active high |
| sense_high | input | 1 | Recovery flag: sense line driven high from outside |
| pwr_fail_n | output | 1 | Active-low early power-fail warning |
| dis_off | output | 1 | High turns the discharge switch off |
| aux_on | output | 1 | High enables the auxiliary supply output to the host |
| sense_pull_low | output | 1 | High pulls the current-sense line low |
| bias_en | output | 1 | High keeps the internal bias on |

## Verification
The assertions assume that pdwn_req and sense_high are low while reset is asserted and on the first edge after it, so that the first past values they look at belong to the normal state. They also assume that tick only ever changes between edges. The bench holds every input low during reset and drives all inputs on the falling clock edge. The random phase changes cell_low rarely, which gives both aborted and completed warning sequences. It pulses pdwn_req and sense_high at low rates so that the machine spends long stretches in every state.

// File: rtl/odp_pkg.sv
package odp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_WARN_WAIT  = 2'd1,
        ST_WARNED     = 2'd2,
        ST_POWER_DOWN = 2'd3
    } odp_state_e;

    typedef struct packed {
        logic pwr_fail_n;
        logic dis_off;
        logic aux_on;
        logic sense_pull_low;
        logic bias_en;
    } odp_out_s;

    function automatic int unsigned odp_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/odp_tick_timer.sv
module odp_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/odp_next_state.sv
module odp_next_state
    import odp_pkg::*;
#(
    parameter int WARN_TICKS      = 8,
    parameter int SHUT_TICKS      = 20,
    parameter int MIN_PULSE_TICKS = 3,
    parameter int CNT_W           = 5
) (
    input  odp_state_e       state,
    input  logic             cell_low,
    input  logic             pdwn_req,
    input  logic             sense_high,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    output odp_state_e       nxt,
    output logic             timer_clear,
    output logic             timer_adv
);

    localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(WARN_TICKS - 1);
    localparam logic [CNT_W-1:0] SHUT_LAST = CNT_W'(SHUT_TICKS - 1);
    localparam logic [CNT_W-1:0] PULSE_MIN = CNT_W'(MIN_PULSE_TICKS);

    logic warn_expired;
    logic shut_expired;
    logic pulse_done;

    assign warn_expired = tick && (count == WARN_LAST);
    assign shut_expired = tick && (count == SHUT_LAST);
    assign pulse_done   = (count >= PULSE_MIN);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL: begin
                if (pdwn_req)      nxt = ST_POWER_DOWN;
                else if (cell_low) nxt = ST_WARN_WAIT;
            end
            ST_WARN_WAIT: begin
                if (pdwn_req)          nxt = ST_POWER_DOWN;
                else if (!cell_low)    nxt = ST_NORMAL;
                else if (warn_expired) nxt = ST_WARNED;
            end
            ST_WARNED: begin
                if (pdwn_req)                     nxt = ST_POWER_DOWN;
                else if (shut_expired)            nxt = ST_POWER_DOWN;
                else if (!cell_low && pulse_done) nxt = ST_NORMAL;
            end
            ST_POWER_DOWN: begin
                if (sense_high) nxt = cell_low ? ST_WARN_WAIT : ST_NORMAL;
            end
            default: nxt = ST_NORMAL;
        endcase
    end

    assign timer_clear = (nxt != state) || (state == ST_NORMAL) || (state == ST_POWER_DOWN);
    assign timer_adv   = tick && ((state == ST_WARN_WAIT) || (state == ST_WARNED));

endmodule

// File: rtl/odp_out_decode.sv
module odp_out_decode
    import odp_pkg::*;
(
    input  odp_state_e state,
    output odp_out_s   outs
);

    always_comb begin
        outs = '{pwr_fail_n: 1'b1, dis_off: 1'b0, aux_on: 1'b1,
                 sense_pull_low: 1'b0, bias_en: 1'b1};
        unique case (state)
            ST_NORMAL, ST_WARN_WAIT: ;
            ST_WARNED: outs.pwr_fail_n = 1'b0;
            ST_POWER_DOWN: begin
                outs.dis_off        = 1'b1;
                outs.aux_on         = 1'b0;
                outs.sense_pull_low = 1'b1;
                outs.bias_en        = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/odp_pwrfail_seq.sv
module odp_pwrfail_seq
    import odp_pkg::*;
#(
    parameter int WARN_TICKS      = 8,
    parameter int SHUT_TICKS      = 20,
    parameter int MIN_PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cell_low,
    input  logic pdwn_req,
    input  logic sense_high,
    output logic pwr_fail_n,
    output logic dis_off,
    output logic aux_on,
    output logic sense_pull_low,
    output logic bias_en
);

    localparam int unsigned LONGEST = odp_max(odp_max(WARN_TICKS, SHUT_TICKS), MIN_PULSE_TICKS);
    localparam int CNT_W = $clog2(LONGEST + 1);

    odp_state_e       state;
    odp_state_e       nxt;
    logic             timer_clear;
    logic             timer_adv;
    logic [CNT_W-1:0] count;
    odp_out_s         outs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= nxt;
    end

    odp_next_state #(
        .WARN_TICKS      (WARN_TICKS),
        .SHUT_TICKS      (SHUT_TICKS),
        .MIN_PULSE_TICKS (MIN_PULSE_TICKS),
        .CNT_W           (CNT_W)
    ) i_next (
        .state       (state),
        .cell_low    (cell_low),
        .pdwn_req    (pdwn_req),
        .sense_high  (sense_high),
        .tick        (tick),
        .count       (count),
        .nxt         (nxt),
        .timer_clear (timer_clear),
        .timer_adv   (timer_adv)
    );

    odp_tick_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .advance (timer_adv),
        .count   (count)
    );

    odp_out_decode i_dec (
        .state (state),
        .outs  (outs)
    );

    assign pwr_fail_n     = outs.pwr_fail_n;
    assign dis_off        = outs.dis_off;
    assign aux_on         = outs.aux_on;
    assign sense_pull_low = outs.sense_pull_low;
    assign bias_en        = outs.bias_en;

endmodule

// File: rtl/odp_pwrfail_chk.sv
module odp_pwrfail_chk #(
    parameter int MIN_PULSE_TICKS = 3
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic pdwn_req,
    input logic sense_high,
    input logic cell_low,
    input logic pwr_fail_n,
    input logic dis_off,
    input logic aux_on,
    input logic sense_pull_low,
    input logic bias_en
);

    int unsigned low_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_ticks <= 0;
        else if (pwr_fail_n)        low_ticks <= 0;
        else if (tick)              low_ticks <= low_ticks + 1;
    end

    // R5
    pd_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_off |-> (!aux_on && !bias_en && sense_pull_low && pwr_fail_n));

    // R2
    warn_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_fail_n) |-> $past(cell_low));

    // R4
    min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_fail_n) && !$past(pdwn_req)) |-> (low_ticks >= MIN_PULSE_TICKS));

    // R6
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dis_off) && !$past(sense_high)) |-> dis_off);

    // R7
    pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dis_off) && $past(sense_high)) |-> (!dis_off && aux_on && bias_en));

    // R11
    pdwn_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pdwn_req) && !$past(dis_off)) |-> dis_off);

endmodule

bind odp_pwrfail_seq odp_pwrfail_chk #(
    .MIN_PULSE_TICKS (MIN_PULSE_TICKS)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .pdwn_req       (pdwn_req),
    .sense_high     (sense_high),
    .cell_low       (cell_low),
    .pwr_fail_n     (pwr_fail_n),
    .dis_off        (dis_off),
    .aux_on         (aux_on),
    .sense_pull_low (sense_pull_low),
    .bias_en        (bias_en)
);

// File: tb/test_odp_pwrfail_seq.sv
module test_odp_pwrfail_seq;

    localparam int W = 8;
    localparam int S = 20;
    localparam int M = 3;
    localparam logic [4:0] V_NORM = 5'b10101;
    localparam logic [4:0] V_WARN = 5'b00101;
    localparam logic [4:0] V_PD   = 5'b11010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cell_low = 1'b0;
    logic pdwn_req = 1'b0;
    logic sense_high = 1'b0;
    logic pwr_fail_n, dis_off, aux_on, sense_pull_low, bias_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    int ms = 0;
    int mc = 0;

    always #10 clk = ~clk;

    odp_pwrfail_seq #(
        .WARN_TICKS (W), .SHUT_TICKS (S), .MIN_PULSE_TICKS (M)
    ) i_odp_pwrfail_seq (
        .clk (clk), .rst_n (rst_n), .tick (tick), .cell_low (cell_low),
        .pdwn_req (pdwn_req), .sense_high (sense_high),
        .pwr_fail_n (pwr_fail_n), .dis_off (dis_off), .aux_on (aux_on),
        .sense_pull_low (sense_pull_low), .bias_en (bias_en)
    );

    function automatic logic [4:0] exp_out(input int st);
        case (st)
            2:       return V_WARN;
            3:       return V_PD;
            default: return V_NORM;
        endcase
    endfunction

    function automatic logic [4:0] dut_out();
        return {pwr_fail_n, dis_off, aux_on, sense_pull_low, bias_en};
    endfunction

    // Reference sequence from the requirements: 0 normal, 1 warn-wait, 2 warned, 3 power-down
    always @(posedge clk) begin
        if (!rst_n) begin
            ms <= 0; mc <= 0;
        end else if (ms == 3) begin
            if (sense_high) begin ms <= cell_low ? 1 : 0; mc <= 0; end
        end else if (pdwn_req) begin
            ms <= 3; mc <= 0;
        end else if (ms == 0) begin
            if (cell_low) ms <= 1;
        end else if (ms == 1) begin
            if (!cell_low) begin ms <= 0; mc <= 0; end
            else if (tick) begin
                if (mc == W - 1) begin ms <= 2; mc <= 0; end
                else mc <= mc + 1;
            end
        end else begin
            if (tick && mc == S - 1) begin ms <= 3; mc <= 0; end
            else if (!cell_low && mc >= M) begin ms <= 0; mc <= 0; end
            else if (tick) mc <= mc + 1;
        end
    end

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && rst_n && !done) check("R2,R5 model", dut_out(), exp_out(ms));
    end

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        adv(3);
        rst_n = 1'b1;
        adv(1);
        check("R1 reset", dut_out(), V_NORM);
        model_on = 1'b1;
        tick = 1'b1;

        // R2 warning delay
        cell_low = 1'b1;
        adv(W);
        check("R2 before warn", dut_out(), V_NORM);
        adv(1);
        check("R2 warn", dut_out(), V_WARN);

        // R4 minimum pulse then abort
        cell_low = 1'b0;
        adv(M);
        check("R4 pulse held", dut_out(), V_WARN);
        adv(1);
        check("R4 abort", dut_out(), V_NORM);

        // R3 abort during warn-wait
        cell_low = 1'b1;
        adv(3);
        cell_low = 1'b0;
        adv(1);
        check("R3 abort", dut_out(), V_NORM);
        adv(W + 2);
        check("R3 no pulse", dut_out(), V_NORM);

        // R5 shutdown
        cell_low = 1'b1;
        adv(W + 1);
        check("R5 warned", dut_out(), V_WARN);
        adv(S - 1);
        check("R5 before shut", dut_out(), V_WARN);
        adv(1);
        check("R5 shutdown", dut_out(), V_PD);

        // R6 inputs ignored in power-down
        for (int i = 0; i < 40; i++) begin
            cell_low = 1'($urandom);
            pdwn_req = 1'($urandom);
            tick     = 1'($urandom);
            adv(1);
        end
        check("R6 held", dut_out(), V_PD);
        pdwn_req = 1'b0;
        tick = 1'b1;

        // R7, R8 recovery with cell still low
        cell_low = 1'b1;
        sense_high = 1'b1;
        adv(1);
        sense_high = 1'b0;
        check("R7 recover", dut_out(), V_NORM);
        adv(W - 1);
        check("R8 before rewarn", dut_out(), V_NORM);
        adv(1);
        check("R8 rewarn", dut_out(), V_WARN);

        // R9 request during warned
        pdwn_req = 1'b1;
        adv(1);
        pdwn_req = 1'b0;
        check("R9 forced", dut_out(), V_PD);

        // R10 recovery with cell ok
        cell_low = 1'b0;
        sense_high = 1'b1;
        adv(1);
        sense_high = 1'b0;
        check("R10 recover", dut_out(), V_NORM);
        adv(W + 3);
        check("R10 quiet", dut_out(), V_NORM);

        // R11 shipping power-down with healthy cells
        pdwn_req = 1'b1;
        adv(1);
        pdwn_req = 1'b0;
        check("R11 forced", dut_out(), V_PD);
        adv(5);
        check("R11 latched", dut_out(), V_PD);
        sense_high = 1'b1;
        adv(1);
        sense_high = 1'b0;
        check("R11 released", dut_out(), V_NORM);

        // R12 tick gating
        tick = 1'b0;
        cell_low = 1'b1;
        adv(3 * W);
        check("R12 no warn", dut_out(), V_NORM);
        tick = 1'b1;
        adv(W);
        check("R12 warn", dut_out(), V_WARN);
        tick = 1'b0;
        cell_low = 1'b0;
        adv(3 * S);
        check("R12 pulse frozen", dut_out(), V_WARN);
        tick = 1'b1;
        adv(M + 1);
        check("R12 abort", dut_out(), V_NORM);

        // Random phase against the reference sequence
        for (int i = 0; i < 6000; i++) begin
            tick = ($urandom_range(1, 0) == 1);
            if ($urandom_range(15, 0) == 0) cell_low = ~cell_low;
            pdwn_req   = ($urandom_range(199, 0) == 0);
            sense_high = ($urandom_range(31, 0) == 0);
            adv(1);
        end
        tick = 1'b0; cell_low = 1'b0; pdwn_req = 1'b0; sense_high = 1'b0;
        adv(2);
        finish_run();
    end

endmodule